// File: doc/BRIEF.md
# Timekeeping Register File with Coherent Time Snapshot

This block is the byte-addressed register space that sits behind a serial-bus slave in a real-time-clock subsystem. A bit-level protocol engine, which is outside this block, decodes the bus. It hands the block single-cycle event strobes: bus start, bus stop, pointer load, byte read and byte write acknowledge. The space has 64 locations. Locations 00h–06h are the seven time and date bytes, 07h is a control byte, and 08h–3Fh are 56 bytes of general-purpose RAM.

A 6-bit pointer selects the location for every byte transferred and steps by one after each byte. When it steps from 3Fh it wraps back to 00h. Reads of the time and date locations do not look at the running calendar counter. They return a held copy of it, the snapshot. The snapshot is refreshed in one cycle on a bus start, on a bus stop, and whenever the pointer steps onto 00h. A multibyte read therefore sees one consistent instant while the counter keeps running. Writes to the time and date locations do not land in the snapshot. They are passed to the counter as a one-hot write strobe with the byte, in the cycle the byte is acknowledged.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the pointer is 00h, `rd_valid`, `rd_data`, `cnt_wr_en` and the control byte are all zero, and the snapshot holds zeros. Reads of 00h–07h before any snapshot event therefore return 00h.
- R2: Each byte read or byte write advances the pointer by one. From 3Fh the pointer wraps to 00h.
- R3: `ev_start`, `ev_stop`, or a pointer step from 3Fh onto 00h copies all seven bytes of `live_time` into the snapshot at the clock edge that ends that cycle. A pointer load of 00h does not copy.
- R4: A read at address a < 7 returns snapshot byte a. Changes on `live_time` with no snapshot event in between are not visible. `live_time[8a+7:8a]` carries the byte of address a.
- R5: Bits that a location does not define are zero on every read and are forced to zero on every write. The masks of defined bits are: 00h 7Fh, 01h 7Fh, 02h 7Fh, 03h 07h, 04h 3Fh, 05h 1Fh, 06h FFh, 07h 93h. RAM bytes use FFh.
- R6: A byte write at address a < 7 raises `cnt_wr_en[a]` alone, in the same cycle as `ev_wr`, with `cnt_wr_data` equal to the written byte under its mask. A write at a ≥ 7 leaves `cnt_wr_en` at zero.
- R7: `ev_ptr_load` sets the pointer to `wr_data[5:0]`, and `wr_data[7:6]` is ignored. If `ev_ptr_load` coincides with `ev_wr` or `ev_rd`, the load wins and no byte moves. If `ev_wr` and `ev_rd` coincide, the write wins.
- R8: The control byte at 07h and the RAM at 08h–3Fh read back the last value written to them, masked as in R5. RAM has no reset value.
- R9: `rd_data` holds the byte read, and `rd_valid` pulses for one cycle, in the cycle after `ev_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Bus start seen (snapshot trigger) |
| ev_stop | input | 1 | Bus stop seen (snapshot trigger) |
| ev_ptr_load | input | 1 | Load the pointer from `wr_data[5:0]` |
| ev_rd | input | 1 | Transfer one byte out at the pointer |
| ev_wr | input | 1 | Byte acknowledged: store `wr_data` at the pointer |
| wr_data | input | 8 | Byte from the bus |
| live_time | input | 56 | Running time/date bytes from the calendar counter |
| rd_data | output | 8 | Byte read, registered |
| rd_valid | output | 1 | `rd_data` valid pulse |
| cnt_wr_en | output | 7 | One-hot write strobe to the counter, one bit per time byte |
| cnt_wr_data | output | 8 | Masked byte for the counter |

## Verification
Assertions check every cycle that the pointer steps, wraps and loads as required. They also check that the snapshot changes only at a snapshot event and then equals the masked live bytes, that the counter strobe is one-hot and silent outside 00h–06h, and that every read produces its valid pulse. Only the bench scenarios can show what a multibyte read returns while `live_time` moves underneath it. The same holds for the choice of which events refresh the snapshot and which, such as a pointer load of 00h, do not. RAM retention across the full wrap, and the masking seen from the bus side, are likewise shown by the scenarios alone.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

  // Defined-bit mask for each byte location; RAM keeps all eight bits.
  function automatic logic [7:0] loc_mask(input int unsigned idx);
    case (idx)
      0, 1, 2: loc_mask = 8'h7F;
      3:       loc_mask = 8'h07;
      4:       loc_mask = 8'h3F;
      5:       loc_mask = 8'h1F;
      6:       loc_mask = 8'hFF;
      7:       loc_mask = 8'h93;
      default: loc_mask = 8'hFF;
    endcase
  endfunction

  // Next pointer value with wrap over the full address space.
  function automatic logic [15:0] ptr_next(input logic [15:0] p, input int unsigned aw);
    logic [15:0] top;
    top = 16'((32'd1 << aw) - 1);
    ptr_next = (p == top) ? 16'd0 : p + 16'd1;
  endfunction

endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              wrap_evt
);
  import rtc_regfile_pkg::*;
  localparam logic [ADDR_W-1:0] TOP = '1;

  assign wrap_evt = step && !ld && (ptr_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (ld) ptr_q <= ld_val;
    else if (step) ptr_q <= ADDR_W'(ptr_next(16'(ptr_q), ADDR_W));
  end

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && ptr_q != TOP) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ptr_q == '0);
  p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> ptr_q == $past(ld_val));
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step) |=> $stable(ptr_q));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int N_TIME = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  snap,
  input  logic [8*N_TIME-1:0]   live_i,
  output logic [8*N_TIME-1:0]   shadow_o
);
  import rtc_regfile_pkg::*;

  for (genvar i = 0; i < N_TIME; i++) begin : g_byte
    logic [7:0] sh_q;
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else if (snap) sh_q <= live_i[8*i +: 8] & loc_mask(i);
    end
    assign shadow_o[8*i +: 8] = sh_q;

    p_snap_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> ((sh_q ^ $past(live_i[8*i +: 8])) & loc_mask(i)) == 8'h00);
    p_snap_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_q & ~loc_mask(i)) == 8'h00);
  end

  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shadow_o));
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int DEPTH = 56,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int ADDR_W = 6,
  parameter int N_TIME = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_start,
  input  logic                ev_stop,
  input  logic                ev_ptr_load,
  input  logic                ev_rd,
  input  logic                ev_wr,
  input  logic [7:0]          wr_data,
  input  logic [8*N_TIME-1:0] live_time,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  output logic [N_TIME-1:0]   cnt_wr_en,
  output logic [7:0]          cnt_wr_data
);
  import rtc_regfile_pkg::*;

  localparam int CTRL_ADDR = N_TIME;
  localparam int RAM_BASE  = N_TIME + 1;
  localparam int RAM_DEPTH = (1 << ADDR_W) - RAM_BASE;

  // Named internal events, used by the assertions below.
  logic              wr_go, rd_go, step, wrap_evt, snap_evt;
  logic              in_time, in_ctrl, in_ram;
  logic [ADDR_W-1:0] ptr_q, ram_idx;
  logic [8*N_TIME-1:0] shadow;
  logic [7:0]        ctrl_q, ram_rdata, sel_byte, cur_mask;

  assign wr_go    = ev_wr && !ev_ptr_load;
  assign rd_go    = ev_rd && !ev_wr && !ev_ptr_load;
  assign step     = wr_go || rd_go;
  assign snap_evt = ev_start || ev_stop || wrap_evt;

  assign in_time  = (ptr_q < ADDR_W'(N_TIME));
  assign in_ctrl  = (ptr_q == ADDR_W'(CTRL_ADDR));
  assign in_ram   = !in_time && !in_ctrl;
  assign ram_idx  = ptr_q - ADDR_W'(RAM_BASE);
  assign cur_mask = loc_mask(int'(ptr_q));

  rtc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(ev_ptr_load), .ld_val(wr_data[ADDR_W-1:0]),
    .step(step), .ptr_q(ptr_q), .wrap_evt(wrap_evt)
  );

  rtc_shadow #(.N_TIME(N_TIME)) u_shadow (
    .clk(clk), .rst_n(rst_n), .snap(snap_evt), .live_i(live_time), .shadow_o(shadow)
  );

  rtc_ram #(.DEPTH(RAM_DEPTH), .IDX_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_go && in_ram), .idx(ram_idx), .wdata(wr_data), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_go && in_ctrl) ctrl_q <= wr_data & cur_mask;
  end

  // Counter write strobes: one bit per time/date location.
  for (genvar i = 0; i < N_TIME; i++) begin : g_cwr
    assign cnt_wr_en[i] = wr_go && (ptr_q == ADDR_W'(i));
  end
  assign cnt_wr_data = wr_data & cur_mask;

  always_comb begin
    if (in_time)      sel_byte = shadow[8*int'(ptr_q) +: 8];
    else if (in_ctrl) sel_byte = ctrl_q;
    else              sel_byte = ram_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= sel_byte;
    end
  end

  p_cnt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_wr_en));
  p_cnt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_time || !ev_wr) |-> cnt_wr_en == '0);
  p_ctrl_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~8'h93) == 8'h00);
  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rd_valid && $stable(rd_data));
  p_wrap_snaps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr_q == '1) |-> snap_evt);
endmodule

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 0, ev_stop = 0, ev_ptr_load = 0, ev_rd = 0, ev_wr = 0;
  logic [7:0]  wr_data = '0;
  logic [55:0] live_time;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [6:0]  cnt_wr_en;
  logic [7:0]  cnt_wr_data;

  logic [7:0]  lv [7];
  logic [7:0]  m_sh [7];
  logic [7:0]  m_ram [64];
  logic [7:0]  m_ctrl;
  logic [5:0]  m_ptr;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  q_exp [$];
  string       q_tag [$];

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < 7; i++) live_time[8*i +: 8] = lv[i];

  rtc_regfile dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_ptr_load(ev_ptr_load), .ev_rd(ev_rd), .ev_wr(ev_wr), .wr_data(wr_data),
    .live_time(live_time), .rd_data(rd_data), .rd_valid(rd_valid),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data)
  );

  function automatic logic [7:0] bmask(input int a);
    logic [7:0] t [8] = '{8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'h93};
    return (a < 8) ? t[a] : 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic take_snapshot();
    for (int i = 0; i < 7; i++) m_sh[i] = lv[i] & bmask(i);
  endtask

  task automatic advance();
    m_ptr = m_ptr + 6'd1;
    if (m_ptr == 6'd0) take_snapshot();
  endtask

  task automatic set_live(input logic [7:0] s);
    for (int i = 0; i < 7; i++) lv[i] = s ^ 8'(i * 8'h4D);
  endtask

  task automatic do_start();
    @(negedge clk); ev_start = 1; take_snapshot();
    @(negedge clk); ev_start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); ev_stop = 1; take_snapshot();
    @(negedge clk); ev_stop = 0;
  endtask

  task automatic do_load(input logic [7:0] v);
    @(negedge clk); ev_ptr_load = 1; wr_data = v; m_ptr = v[5:0];
    @(negedge clk); ev_ptr_load = 0;
  endtask

  task automatic do_read(input string tag);
    logic [7:0] e;
    @(negedge clk);
    ev_rd = 1;
    if (m_ptr < 7) e = m_sh[m_ptr];
    else if (m_ptr == 7) e = m_ctrl;
    else e = m_ram[m_ptr];
    q_exp.push_back(e);
    q_tag.push_back(tag);
    advance();
    @(negedge clk); ev_rd = 0;
  endtask

  task automatic do_write(input logic [7:0] v, input string tag);
    @(negedge clk);
    ev_wr = 1; wr_data = v;
    #1;
    if (m_ptr < 7) begin
      check({tag, " R6 strobe"}, 32'(cnt_wr_en), 32'(7'b1 << m_ptr));
      check({tag, " R5 cnt data mask"}, 32'(cnt_wr_data), 32'(v & bmask(m_ptr)));
    end else begin
      check({tag, " R6 no strobe"}, 32'(cnt_wr_en), 32'd0);
      if (m_ptr == 7) m_ctrl = v & bmask(7);
      else m_ram[m_ptr] = v;
    end
    advance();
    @(negedge clk); ev_wr = 0;
  endtask

  // Monitor: compares each produced read byte with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected rd_valid, actual %h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, 32'(rd_data), 32'(e));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_ptr = 0; m_ctrl = 0;
    for (int i = 0; i < 7; i++) m_sh[i] = 0;
    set_live(8'hD9);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    check("R1 cnt_wr_en", 32'(cnt_wr_en), 0);
    // R1: pointer at 00h, snapshot and control zero.
    for (int i = 0; i < 8; i++) do_read("R1 reset read");

    // R3/R4: snapshot on start, live changes mid-read hidden.
    set_live(8'hE7);
    do_start();
    do_load(8'h00);
    for (int i = 0; i < 3; i++) do_read("R4 coherent read A");
    set_live(8'h3C);
    for (int i = 0; i < 4; i++) do_read("R4 coherent read B");
    do_read("R8 ctrl after reset");
    // R3: pointer load of 00h does not refresh.
    do_load(8'h00);
    do_read("R3 load-to-zero no snapshot");

    // R2/R3/R8: fill RAM, last write wraps and refreshes snapshot.
    set_live(8'hFF);
    do_load(8'h08);
    for (int i = 8; i < 64; i++) do_write(8'(i * 37 + 5), "R8 ram fill");
    check("R2 wrap ptr model", 32'(m_ptr), 0);
    do_read("R3 wrap-by-write snapshot");

    // R7: upper bits of load ignored.
    do_load(8'hC9);
    do_read("R7 load 09h");

    // R5/R8: control byte masking.
    do_load(8'h07);
    do_write(8'hFF, "R8 ctrl write");
    do_load(8'h07);
    do_read("R5 ctrl masked");

    // R6: counter strobes with masked data.
    do_load(8'h00);
    for (int i = 0; i < 7; i++) do_write(8'hFF, "R6 time write");
    do_write(8'h10, "R6 ctrl write");

    // R2/R3: read across wrap picks up fresh time.
    set_live(8'h5A);
    do_load(8'h3E);
    for (int i = 0; i < 3; i++) do_read("R2 read across wrap");
    do_read("R3 wrap-by-read snapshot");

    // R3: stop refreshes.
    set_live(8'hA5);
    do_stop();
    do_load(8'h01);
    do_read("R3 stop snapshot");

    // R7: load wins over a simultaneous write.
    @(negedge clk); ev_ptr_load = 1; ev_wr = 1; wr_data = 8'h0A; m_ptr = 6'h0A;
    #1 check("R7 load beats write strobe", 32'(cnt_wr_en), 0);
    @(negedge clk); ev_ptr_load = 0; ev_wr = 0;
    do_read("R7 load priority keeps ram");

    // R8: full RAM retention.
    do_load(8'h08);
    for (int i = 8; i < 64; i++) do_read("R8 ram readback");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 32'(q_exp.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule